// File: doc/BRIEF.md
# Fast Ethernet Receive Line Decoder

This block turns a stream of already-sliced three-level line symbols back into 4-bit receive nibbles. One symbol arrives with each pulse of a recovered bit strobe (nominally 125 MHz). Every change of level between two consecutive symbols counts as a line transition, and every transition is a logical 1. The resulting serial bits are framed into 5-bit code groups. Group boundaries come from the start-of-stream delimiter pair, and each group is decoded to a 4-bit nibble.

The block also produces a receive clock at one fifth of the bit rate. Nibbles and their valid flag change on the falling edge of this clock so that a receiver samples them on the rising edge. While the `sig_ok` input is low, the block takes its bit timing from a local reference divider, so the receive clock keeps running through idle periods. All logic runs on one fast core clock. The bit strobe and the reference tick act as clock enables.

Top module: `rx_line_decoder`

## Requirements
- R1: `sym_level` is a 2-bit two's-complement level (2'b01 = +1, 2'b00 = 0, 2'b11 = -1). On each bit strobe while `sig_ok` is high, a level that differs from the previous one decodes as serial bit 1, including a direct jump from +1 to -1. An unchanged level decodes as serial bit 0.
- R2: Group alignment is set only by the 10-bit pattern 11000 followed by 10001, in arrival order. Bits received before that pattern are ignored. `rxdv` is low in the cycle after the pattern is found.
- R3: While aligned, each group of 5 bits (first-received bit is the MSB) is decoded as follows. Codes 11110, 01001, 10100 and 10101 give nibbles 0 to 3. Codes 01010, 01011, 01110 and 01111 give 4 to 7. Codes 10010, 10011, 10110 and 10111 give 8 to B. Codes 11010, 11011, 11100 and 11101 give C to F.
- R4: `rxdv` rises together with the first decoded data nibble after the delimiter pair. The delimiter pair itself is never presented with `rxdv` high.
- R5: A group that is not a data code drops `rxdv` and alignment, and forces `rxd` to 0. This includes the end delimiter 01101. Both stay low until the next start pair.
- R6: While `sig_ok` stays high, `rxd` and `rxdv` change only in the same cycle in which `rxc` falls. `rxc` is low for the first 2 bit periods of each 5-bit period and high for the other 3.
- R7: While `sig_ok` is low, bit timing comes from an internal tick every `REF_DIV` core clocks. `rxc` keeps running with a period of 5*`REF_DIV` clocks. `rxdv` is low one clock after `sig_ok` falls, and alignment is lost.
- R8: After reset, `rxc`, `rxdv` and `rxd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_ok | input | 1 | Recovered bit timing is valid |
| bit_en | input | 1 | Recovered bit strobe, one pulse per symbol |
| sym_level | input | 2 | Sliced line level, signed |
| rxc | output | 1 | Receive clock, one fifth of the bit rate |
| rxd | output | 4 | Decoded receive nibble |
| rxdv | output | 1 | Receive data valid |

## Verification
A wrong bit phase counter shows up at the ports within one nibble time. Either `rxd` changes while `rxc` is high, or the `rxc` period departs from 5 bit periods. A wrong line decode or a wrong shift register causes a missed start pair, so no nibble is captured, or it causes wrong nibble values in the first data group. A stuck alignment flag shows up as `rxdv` staying high after the end delimiter or after an invalid group, within one group time of that group.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int GRP_W  = 5;
  localparam int NIB_W  = 4;
  localparam int PAIR_W = 2 * GRP_W;
  localparam logic [PAIR_W-1:0] START_PAIR = 10'b11000_10001;
  localparam logic [2:0] LAST_PH = 3'(GRP_W - 1);

  typedef struct packed {
    logic             ok;
    logic [NIB_W-1:0] nib;
  } dec_t;

  // a serial 1 is any change of line level
  function automatic logic level_moved(input logic [1:0] now_l, input logic [1:0] was_l);
    return now_l != was_l;
  endfunction

  function automatic dec_t decode_group(input logic [GRP_W-1:0] c);
    dec_t d;
    d.ok = 1'b1;
    unique case (c)
      5'b11110: d.nib = 4'h0;  5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;  5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;  5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;  5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;  5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;  5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;  5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;  5'b11101: d.nib = 4'hF;
      default: begin d.ok = 1'b0; d.nib = 4'h0; end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rxd_level_decode.sv
module rxd_level_decode
  import rxd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_ok,
  input  logic       strobe,
  input  logic [1:0] sym_level,
  output logic       nrz_bit
);
  logic [1:0] prev_lvl;

  assign nrz_bit = level_moved(sym_level, prev_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n)                  prev_lvl <= 2'b00;
    else if (!sig_ok || strobe)  prev_lvl <= sym_level;
  end

  // a decoded 1 must leave a moved history level behind
  assert_one_means_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && sig_ok && nrz_bit) |=> (prev_lvl != $past(prev_lvl)));
endmodule

// File: rtl/rxd_timebase.sv
module rxd_timebase
  import rxd_pkg::*;
#(
  parameter int REF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_ok,
  input  logic bit_en,
  input  logic realign,
  output logic strobe,
  output logic grp_done,
  output logic rxc
);
  localparam int RW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [RW-1:0] REF_LAST = RW'(REF_DIV - 1);

  logic [RW-1:0] rdiv;
  logic          ref_tick;
  logic [2:0]    ph;

  generate
    if (REF_DIV > 1) begin : g_div
      always_ff @(posedge clk) begin
        if (!rst_n)                rdiv <= '0;
        else if (rdiv == REF_LAST) rdiv <= '0;
        else                       rdiv <= rdiv + 1'b1;
      end
      assign ref_tick = (rdiv == REF_LAST);
    end else begin : g_nodiv
      assign rdiv     = '0;
      assign ref_tick = 1'b1;
    end
  endgenerate

  assign strobe   = sig_ok ? bit_en : ref_tick;
  assign grp_done = strobe && (ph == LAST_PH);
  assign rxc      = (ph >= 3'd2);

  always_ff @(posedge clk) begin
    if (!rst_n)                   ph <= '0;
    else if (strobe) begin
      if (realign || grp_done)    ph <= '0;
      else                        ph <= ph + 1'b1;
    end
  end

  // a completed group always ends the high part of the receive clock
  assert_grp_end_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> $fell(rxc));
endmodule

// File: rtl/rxd_aligner.sv
module rxd_aligner
  import rxd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_ok,
  input  logic             strobe,
  input  logic             nrz_bit,
  input  logic             grp_done,
  output logic             realign,
  output logic [NIB_W-1:0] rxd,
  output logic             rxdv
);
  logic [PAIR_W-1:0] sr;
  logic [PAIR_W-1:0] next_sr;
  logic              aligned;
  logic              take_grp;
  dec_t              dec;

  assign next_sr  = {sr[PAIR_W-2:0], nrz_bit};
  assign realign  = strobe && sig_ok && !aligned && (next_sr == START_PAIR);
  assign take_grp = sig_ok && aligned && grp_done;
  assign dec      = decode_group(next_sr[GRP_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n || !sig_ok) begin
      sr <= '0; aligned <= 1'b0; rxd <= '0; rxdv <= 1'b0;
    end else if (strobe) begin
      sr <= next_sr;
      if (realign) begin
        aligned <= 1'b1; rxd <= '0; rxdv <= 1'b0;
      end else if (take_grp) begin
        if (dec.ok) begin
          rxd <= dec.nib; rxdv <= 1'b1;
        end else begin
          rxd <= '0; rxdv <= 1'b0; aligned <= 1'b0;
        end
      end
    end
  end

  assert_start_pair_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (!rxdv && aligned));
  assert_end_code_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_grp && next_sr[GRP_W-1:0] == 5'b01101) |=> (!rxdv && !aligned));
endmodule

// File: rtl/rx_line_decoder.sv
module rx_line_decoder
  import rxd_pkg::*;
#(
  parameter int REF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_ok,
  input  logic             bit_en,
  input  logic [1:0]       sym_level,
  output logic             rxc,
  output logic [NIB_W-1:0] rxd,
  output logic             rxdv
);
  logic strobe, nrz_bit, grp_done, realign;

  rxd_level_decode lvl_i (
    .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok), .strobe(strobe),
    .sym_level(sym_level), .nrz_bit(nrz_bit));

  rxd_timebase #(.REF_DIV(REF_DIV)) tb_i (
    .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok), .bit_en(bit_en),
    .realign(realign), .strobe(strobe), .grp_done(grp_done), .rxc(rxc));

  rxd_aligner al_i (
    .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok), .strobe(strobe),
    .nrz_bit(nrz_bit), .grp_done(grp_done), .realign(realign),
    .rxd(rxd), .rxdv(rxdv));

  assert_data_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_ok && $past(sig_ok) && !$stable(rxd)) |-> $fell(rxc));
  assert_valid_rises_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxdv) |-> $fell(rxc));
  assert_no_valid_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_ok |=> !rxdv);
endmodule

// File: tb/rx_line_decoder_tb.sv
module rx_line_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sig_ok = 1'b0;
  logic       bit_en = 1'b0;
  logic [1:0] sym_level = 2'b00;
  logic       rxc;
  logic [3:0] rxd;
  logic       rxdv;

  always #2 clk = ~clk;

  rx_line_decoder #(.REF_DIV(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok), .bit_en(bit_en),
    .sym_level(sym_level), .rxc(rxc), .rxd(rxd), .rxdv(rxdv));

  int checks = 0, fails = 0, cyc = 0;
  int mi = 0;
  bit jumpy = 0;
  bit meas_en = 0, cap_en = 0;
  int last_rise = -1;
  logic [3:0] cap [0:63];
  logic [3:0] expn [0:63];
  int ncap = 0, nexp = 0;
  logic prev_rxc = 0, prev_dv = 0, prev_ok = 0;
  logic [3:0] prev_rxd = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_test();
  end

  always @(posedge clk) cyc++;

  // bench-side 4-bit to 5-bit table, first-sent bit is MSB
  function automatic logic [4:0] enc5(input logic [3:0] n);
    logic [4:0] t [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                           5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
    return t[n];
  endfunction

  function automatic logic [1:0] lvl_of(input int i);
    case (i)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic send_bit(input bit b);
    @(negedge clk);
    if (b) begin
      if (jumpy) begin
        logic [1:0] nl;
        do nl = lvl_of($urandom_range(1, 3)); while (nl == sym_level);
        sym_level = nl;
      end else begin
        mi = (mi + 1) % 4;
        sym_level = lvl_of(mi);
      end
    end
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_grp(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) send_bit(c[i]);
  endtask

  // sampling point 1 ns after the active edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (sig_ok && prev_ok && (rxd != prev_rxd || rxdv != prev_dv))
        chk(prev_rxc && !rxc, "R6 output change off rxc fall", int'(rxc), 0);
      if (rxc && !prev_rxc) begin
        if (cap_en && rxdv && ncap < 64) begin cap[ncap] = rxd; ncap++; end
        if (meas_en && last_rise >= 0)
          chk(cyc - last_rise == 10, "R7 rxc period", cyc - last_rise, 10);
        last_rise = cyc;
      end
      prev_rxc = rxc; prev_rxd = rxd; prev_dv = rxdv; prev_ok = sig_ok;
    end
  end

  task automatic send_frame(input int n, input int bad_at);
    int k;
    ncap = 0; nexp = 0; cap_en = 1;
    k = $urandom_range(0, 12);
    for (int i = 0; i < k; i++) send_bit(1'b1);
    send_grp(5'b11111);
    send_grp(5'b11000);
    send_grp(5'b10001);
    chk(rxdv == 1'b0, "R2 rxdv low after start pair", int'(rxdv), 0);
    for (int i = 0; i < n; i++) begin
      if (i == bad_at) begin
        send_grp(5'b00000);
        break;
      end else begin
        logic [3:0] nb;
        nb = 4'($urandom_range(0, 15));
        send_grp(enc5(nb));
        expn[nexp] = nb; nexp++;
      end
    end
    if (bad_at < 0) begin
      send_grp(5'b01101);
      send_grp(5'b00111);
    end
    for (int i = 0; i < 4; i++) send_grp(5'b11111);
    cap_en = 0;
    chk(ncap == nexp, "R4 nibble count", ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++)
      chk(cap[i] == expn[i], "R3 nibble value", int'(cap[i]), int'(expn[i]));
    chk(rxdv == 1'b0, "R5 rxdv low after end or bad group", int'(rxdv), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rxc == 1'b0, "R8 rxc after reset", int'(rxc), 0);
    chk(rxdv == 1'b0, "R8 rxdv after reset", int'(rxdv), 0);
    chk(rxd == 4'h0, "R8 rxd after reset", int'(rxd), 0);

    // R7: free-running receive clock without lock
    last_rise = -1; meas_en = 1;
    repeat (80) @(negedge clk);
    meas_en = 0;

    sig_ok = 1'b1;
    // R1 R2 R3 R4 R5: normal frames with stepped levels
    send_frame(8, -1);
    send_frame(1, -1);
    for (int f = 0; f < 6; f++) send_frame($urandom_range(2, 20), -1);
    // R1: arbitrary level jumps, including +1 to -1
    jumpy = 1;
    send_frame(12, -1);
    send_frame(5, -1);
    jumpy = 0;
    // R5: invalid group cuts the frame
    send_frame(10, 4);
    send_frame(6, 0);

    // R7: losing lock mid-frame
    send_grp(5'b11111);
    send_grp(5'b11000);
    send_grp(5'b10001);
    send_grp(enc5(4'h7));
    send_grp(enc5(4'h2));
    chk(rxdv == 1'b1, "R4 rxdv high inside frame", int'(rxdv), 1);
    @(negedge clk);
    sig_ok = 1'b0;
    @(negedge clk);
    chk(rxdv == 1'b0, "R7 rxdv low after lock loss", int'(rxdv), 0);
    repeat (12) @(negedge clk);
    last_rise = -1; meas_en = 1;
    repeat (60) @(negedge clk);
    meas_en = 0;
    // locked timing after relock, then a frame
    sig_ok = 1'b1;
    send_frame(9, -1);
    finish_test();
  end
endmodule